// File: doc/BRIEF.md
# Partitioned Multi-FIFO Shared Memory

This block holds six independent circular FIFOs inside one 4096-word memory of 32-bit quadlets. Software sets the region of each FIFO in granules of 64 quadlets. It writes a 6-bit first-granule field and a 6-bit last-granule field into a per-FIFO size register. Those registers are reached indirectly: software first loads an index into an index register, then reads or writes a data register. Each FIFO's read and write pointers walk its own region and wrap from the region's last quadlet back to its first. They do not wrap at a power-of-two boundary.

Each FIFO has a push port and a pop port, together with full and empty flags and an occupancy count. A single arbiter grants at most one memory access per cycle. A write to the data register takes the whole cycle. Otherwise the lowest-numbered FIFO wins, and a FIFO's push wins over its own pop. A request that loses arbitration sees its ready signal stay low and must be held. Popped data appears one cycle after the grant.

Top module: `mfifo_shared_mem`

## Requirements
- R1: After reset the partition is FIFO0 granules 0–3, FIFO1 4–7, FIFO2 8–11, FIFO3 12–15, FIFO4 16–31 and FIFO5 32–47. FIFO0's size register therefore reads 0x00000003 and FIFO5's reads 0x0000202F. Every FIFO is empty and not full, every count is zero, and the index register reads zero.
- R2: A size register keeps the first-granule field in bits 13..8 and the last-granule field in bits 5..0. All other bits read as zero, whatever was written to them.
- R3: Size registers sit at indices 0x100 to 0x105, one per FIFO in FIFO order. cfg_sel_i=0 selects the index register and cfg_sel_i=1 selects the data register. A data access at any other index reads zero and changes nothing.
- R4: A FIFO's capacity is (last − first + 1) × 64 quadlets. full_o is high when the count equals the capacity, and a push while full is not granted.
- R5: empty_o is high when the count is zero, and a pop while empty is not granted.
- R6: Data leaves each FIFO in the order it entered. The popped word is on pop_data_o, with its pop_rvalid_o bit high, in the cycle after the pop is granted.
- R7: A pointer that advances from the last quadlet of its region goes to the first quadlet {first, 000000} of that region.
- R8: Writing a FIFO's size register flushes that FIFO. Its count becomes zero, it becomes empty, and no earlier data can be popped.
- R9: At most one push or pop is granted per cycle. A data-register write grants none. Among the remaining requests the lower FIFO number wins, and within one FIFO the push wins over the pop.
- R10: A push or pop that is not granted leaves that FIFO unchanged. It is granted in a later cycle while its valid stays high and nothing of higher priority competes.
- R11: FIFOs in disjoint regions do not corrupt each other's data, including when pointers wrap.
- R12: count_o rises by one on each granted push and falls by one on each granted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects the index register, 1 selects the data register |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Contents of the selected register |
| push_valid_i | input | 6 | Push request, one bit per FIFO |
| push_data_i | input | 192 | Push data, 32 bits per FIFO, FIFO k at bits 32k+31..32k |
| push_ready_o | output | 6 | Push granted this cycle |
| pop_valid_i | input | 6 | Pop request, one bit per FIFO |
| pop_ready_o | output | 6 | Pop granted this cycle |
| pop_rvalid_o | output | 6 | Pop data valid, one cycle after the grant |
| pop_data_o | output | 32 | Popped word |
| full_o | output | 6 | Count equals capacity |
| empty_o | output | 6 | Count is zero |
| count_o | output | 78 | Occupancy, 13 bits per FIFO, FIFO k at bits 13k+12..13k |

## Verification
The assertions check the following on every cycle: at most one grant, no grant during a data-register write, no push granted to a full FIFO, no pop granted to an empty one, a count step of one after each grant, and read-valid one cycle after a pop grant. Only the bench's scenarios can show the rest. These are the reset partition values, the field layout, the index decoding, the data order across a pointer wrap, the isolation between neighbouring regions, the flush on reprogramming, and a held request completing once it wins arbitration.

// File: rtl/mfifo_pkg.sv
package mfifo_pkg;
  localparam int NUM_FIFO  = 6;
  localparam int WORD_W    = 32;
  localparam int PADDR_W   = 12;
  localparam int GRAN_W    = 6;
  localparam int INDEX_W   = 12;
  localparam int INDEX_BASE = 'h100;
  localparam int FIRST_LSB = 8;

  // reset partition: first and last granule per FIFO
  function automatic int rst_first(int k);
    case (k)
      0: return 0;
      1: return 4;
      2: return 8;
      3: return 12;
      4: return 16;
      5: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic int rst_last(int k);
    case (k)
      0: return 3;
      1: return 7;
      2: return 11;
      3: return 15;
      4: return 31;
      5: return 47;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/mfifo_cfg.sv
module mfifo_cfg
  import mfifo_pkg::*;
#(
  parameter int N_FIFO  = NUM_FIFO,
  parameter int BANK_W  = 6,
  parameter int IDX_W   = INDEX_W,
  parameter int DATA_W  = WORD_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic                     cfg_sel_i,
  input  logic [DATA_W-1:0]        cfg_wdata_i,
  output logic [DATA_W-1:0]        cfg_rdata_o,
  output logic [N_FIFO*BANK_W-1:0] first_o,
  output logic [N_FIFO*BANK_W-1:0] last_o,
  output logic [BANK_W-1:0]        new_first_o,
  output logic [N_FIFO-1:0]        flush_o
);
  logic [IDX_W-1:0]  idx_q;
  logic [BANK_W-1:0] first_q [N_FIFO];
  logic [BANK_W-1:0] last_q  [N_FIFO];
  logic [N_FIFO-1:0] hit;
  logic              unused_wdata;

  assign unused_wdata = ^cfg_wdata_i;
  assign new_first_o  = cfg_wdata_i[FIRST_LSB +: BANK_W];

  always_comb begin
    for (int k = 0; k < N_FIFO; k++)
      hit[k] = (idx_q == IDX_W'(INDEX_BASE + k));
  end

  assign flush_o = (cfg_we_i && cfg_sel_i) ? hit : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      for (int k = 0; k < N_FIFO; k++) begin
        first_q[k] <= BANK_W'(rst_first(k));
        last_q[k]  <= BANK_W'(rst_last(k));
      end
    end else if (cfg_we_i) begin
      if (!cfg_sel_i) idx_q <= cfg_wdata_i[IDX_W-1:0];
      else begin
        for (int k = 0; k < N_FIFO; k++) begin
          if (hit[k]) begin
            first_q[k] <= cfg_wdata_i[FIRST_LSB +: BANK_W];
            last_q[k]  <= cfg_wdata_i[BANK_W-1:0];
          end
        end
      end
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (!cfg_sel_i) cfg_rdata_o[IDX_W-1:0] = idx_q;
    else begin
      for (int k = 0; k < N_FIFO; k++) begin
        if (hit[k]) begin
          cfg_rdata_o[FIRST_LSB +: BANK_W] = first_q[k];
          cfg_rdata_o[BANK_W-1:0]          = last_q[k];
        end
      end
    end
  end

  for (genvar k = 0; k < N_FIFO; k++) begin : g_out
    assign first_o[k*BANK_W +: BANK_W] = first_q[k];
    assign last_o[k*BANK_W +: BANK_W]  = last_q[k];
  end
endmodule

// File: rtl/mfifo_arb.sv
module mfifo_arb #(
  parameter int N_REQ = 12
) (
  input  logic [N_REQ-1:0] req_i,
  input  logic             block_i,
  output logic [N_REQ-1:0] gnt_o
);
  logic found;

  always_comb begin
    gnt_o = '0;
    found = block_i;
    for (int i = 0; i < N_REQ; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mfifo_ctrl.sv
module mfifo_ctrl #(
  parameter int ADDR_W   = 12,
  parameter int BANK_W   = 6,
  parameter int RST_BANK = 0,
  localparam int OFF_W   = ADDR_W - BANK_W,
  localparam int CNT_W   = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] first_i,
  input  logic [BANK_W-1:0] last_i,
  input  logic [BANK_W-1:0] new_first_i,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] raddr_o
);
  logic [ADDR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q, cap;

  assign cap     = (CNT_W'(last_i) - CNT_W'(first_i) + CNT_W'(1)) << OFF_W;
  assign full_o  = (cnt_q == cap);
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign waddr_o = wptr_q;
  assign raddr_o = rptr_q;

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] p);
    return (p == {last_i, {OFF_W{1'b1}}}) ? {first_i, {OFF_W{1'b0}}} : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= {BANK_W'(RST_BANK), {OFF_W{1'b0}}};
      rptr_q <= {BANK_W'(RST_BANK), {OFF_W{1'b0}}};
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= {new_first_i, {OFF_W{1'b0}}};
      rptr_q <= {new_first_i, {OFF_W{1'b0}}};
      cnt_q  <= '0;
    end else if (push_i) begin
      wptr_q <= step(wptr_q);
      cnt_q  <= cnt_q + 1'b1;
    end else if (pop_i) begin
      rptr_q <= step(rptr_q);
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/mfifo_shared_mem.sv
module mfifo_shared_mem
  import mfifo_pkg::*;
#(
  parameter int N_FIFO = NUM_FIFO,
  parameter int DATA_W = WORD_W,
  parameter int ADDR_W = PADDR_W,
  parameter int BANK_W = GRAN_W,
  localparam int CNT_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic                     cfg_sel_i,
  input  logic [DATA_W-1:0]        cfg_wdata_i,
  output logic [DATA_W-1:0]        cfg_rdata_o,
  input  logic [N_FIFO-1:0]        push_valid_i,
  input  logic [N_FIFO*DATA_W-1:0] push_data_i,
  output logic [N_FIFO-1:0]        push_ready_o,
  input  logic [N_FIFO-1:0]        pop_valid_i,
  output logic [N_FIFO-1:0]        pop_ready_o,
  output logic [N_FIFO-1:0]        pop_rvalid_o,
  output logic [DATA_W-1:0]        pop_data_o,
  output logic [N_FIFO-1:0]        full_o,
  output logic [N_FIFO-1:0]        empty_o,
  output logic [N_FIFO*CNT_W-1:0]  count_o
);
  logic [N_FIFO*BANK_W-1:0] first_v, last_v;
  logic [BANK_W-1:0]        new_first;
  logic [N_FIFO-1:0]        flush;
  logic [2*N_FIFO-1:0]      req, gnt;
  logic [ADDR_W-1:0]        waddr_v [N_FIFO];
  logic [ADDR_W-1:0]        raddr_v [N_FIFO];
  logic [ADDR_W-1:0]        waddr, raddr;
  logic [DATA_W-1:0]        wdata, rd_q;
  logic [DATA_W-1:0]        mem [DEPTH];

  mfifo_cfg #(.N_FIFO(N_FIFO), .BANK_W(BANK_W), .IDX_W(INDEX_W), .DATA_W(DATA_W)) cfg_i (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i, .cfg_rdata_o,
    .first_o(first_v), .last_o(last_v), .new_first_o(new_first), .flush_o(flush)
  );

  // request order: push of FIFO k at 2k, pop at 2k+1
  for (genvar k = 0; k < N_FIFO; k++) begin : g_fifo
    assign req[2*k]     = push_valid_i[k] && !full_o[k];
    assign req[2*k+1]   = pop_valid_i[k] && !empty_o[k];
    assign push_ready_o[k] = gnt[2*k];
    assign pop_ready_o[k]  = gnt[2*k+1];

    mfifo_ctrl #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .RST_BANK(rst_first(k))) ctrl_i (
      .clk_i, .rst_ni,
      .first_i(first_v[k*BANK_W +: BANK_W]),
      .last_i(last_v[k*BANK_W +: BANK_W]),
      .new_first_i(new_first),
      .flush_i(flush[k]),
      .push_i(gnt[2*k]),
      .pop_i(gnt[2*k+1]),
      .full_o(full_o[k]),
      .empty_o(empty_o[k]),
      .count_o(count_o[k*CNT_W +: CNT_W]),
      .waddr_o(waddr_v[k]),
      .raddr_o(raddr_v[k])
    );
  end

  mfifo_arb #(.N_REQ(2*N_FIFO)) arb_i (
    .req_i(req), .block_i(cfg_we_i && cfg_sel_i), .gnt_o(gnt)
  );

  always_comb begin
    waddr = '0;
    raddr = '0;
    wdata = '0;
    for (int k = 0; k < N_FIFO; k++) begin
      if (push_ready_o[k]) begin
        waddr = waddr_v[k];
        wdata = push_data_i[k*DATA_W +: DATA_W];
      end
      if (pop_ready_o[k]) raddr = raddr_v[k];
    end
  end

  always_ff @(posedge clk_i) begin
    if (|push_ready_o) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pop_rvalid_o <= '0;
    else         pop_rvalid_o <= pop_ready_o;
  end

  assign pop_data_o = rd_q;
endmodule

// File: rtl/mfifo_shared_mem_chk.sv
module mfifo_shared_mem_chk #(
  parameter int N_FIFO = 6,
  parameter int CNT_W  = 13
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cfg_we_i,
  input logic                    cfg_sel_i,
  input logic [N_FIFO-1:0]       push_ready_o,
  input logic [N_FIFO-1:0]       pop_ready_o,
  input logic [N_FIFO-1:0]       pop_rvalid_o,
  input logic [N_FIFO-1:0]       full_o,
  input logic [N_FIFO-1:0]       empty_o,
  input logic [N_FIFO*CNT_W-1:0] count_o
);
  a_r9_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({push_ready_o, pop_ready_o}));

  a_r9_cfg_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i) |-> (push_ready_o == '0 && pop_ready_o == '0));

  a_r6_rvalid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pop_rvalid_o == $past(pop_ready_o));

  for (genvar k = 0; k < N_FIFO; k++) begin : g_k
    a_r4_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_o[k] |-> !push_ready_o[k]);

    a_r5_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      empty_o[k] |-> !pop_ready_o[k]);

    a_r12_push_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_ready_o[k] |=> count_o[k*CNT_W +: CNT_W] == $past(count_o[k*CNT_W +: CNT_W]) + 1'b1);

    a_r12_pop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_ready_o[k] |=> count_o[k*CNT_W +: CNT_W] == $past(count_o[k*CNT_W +: CNT_W]) - 1'b1);
  end
endmodule

bind mfifo_shared_mem mfifo_shared_mem_chk #(.N_FIFO(N_FIFO), .CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
  .push_ready_o(push_ready_o), .pop_ready_o(pop_ready_o), .pop_rvalid_o(pop_rvalid_o),
  .full_o(full_o), .empty_o(empty_o), .count_o(count_o)
);

// File: tb/mfifo_shared_mem_tb_top.sv
module mfifo_shared_mem_tb_top;
  localparam int NF = 6;
  localparam int DW = 32;
  localparam int CW = 13;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           cfg_we_i = 1'b0;
  logic           cfg_sel_i = 1'b0;
  logic [DW-1:0]  cfg_wdata_i = '0;
  logic [DW-1:0]  cfg_rdata_o;
  logic [NF-1:0]  push_valid_i = '0;
  logic [NF*DW-1:0] push_data_i = '0;
  logic [NF-1:0]  push_ready_o;
  logic [NF-1:0]  pop_valid_i = '0;
  logic [NF-1:0]  pop_ready_o, pop_rvalid_o;
  logic [DW-1:0]  pop_data_o;
  logic [NF-1:0]  full_o, empty_o;
  logic [NF*CW-1:0] count_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  mfifo_shared_mem dut_i (.*);

  // {index, expected size-register value} after reset
  localparam logic [43:0] VEC [8] = '{
    {12'h100, 32'h0000_0003}, {12'h101, 32'h0000_0407},
    {12'h102, 32'h0000_080B}, {12'h103, 32'h0000_0C0F},
    {12'h104, 32'h0000_101F}, {12'h105, 32'h0000_202F},
    {12'h106, 32'h0000_0000}, {12'h0FF, 32'h0000_0000}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cnt(int k);
    return 32'(count_o[k*CW +: CW]);
  endfunction

  task automatic cfg_wr(bit sel, logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic cfg_rd(bit sel, output logic [31:0] d);
    @(negedge clk_i);
    cfg_sel_i = sel;
    #1 d = cfg_rdata_o;
  endtask

  task automatic do_push(int k, logic [31:0] d, output bit g);
    @(negedge clk_i);
    push_valid_i[k] = 1'b1; push_data_i[k*DW +: DW] = d;
    #1 g = push_ready_o[k];
    @(negedge clk_i);
    push_valid_i[k] = 1'b0;
  endtask

  task automatic do_pop(int k, output bit g, output logic [31:0] d);
    @(negedge clk_i);
    pop_valid_i[k] = 1'b1;
    #1 g = pop_ready_o[k];
    @(negedge clk_i);
    pop_valid_i[k] = 1'b0;
    d = g ? pop_data_o : 32'hDEAD_BEEF;
    if (g) chk("R6 rvalid", 32'(pop_rvalid_o[k]), 32'd1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    bit g;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 empty", 32'(empty_o), 32'h3F);
    chk("R1 full", 32'(full_o), 32'h0);
    chk("R1 count", 32'(|count_o), 32'h0);
    cfg_rd(1'b0, d);
    chk("R1 index reg", d, 32'h0);

    // R1/R3 vector walk over size registers
    for (int i = 0; i < 8; i++) begin
      cfg_wr(1'b0, 32'(VEC[i][43:32]));
      cfg_rd(1'b1, d);
      chk($sformatf("R1 R3 size idx 0x%0h", VEC[i][43:32]), d, VEC[i][31:0]);
    end

    // R2 field layout, stray bits read zero
    cfg_wr(1'b0, 32'h100);
    cfg_wr(1'b1, 32'hFFFF_C0C3);
    cfg_rd(1'b1, d);
    chk("R2 layout", d, 32'h0000_0003);
    cfg_wr(1'b1, 32'h0000_0000);
    cfg_rd(1'b1, d);
    chk("R2 one granule", d, 32'h0);

    // R3 write to unmapped index ignored
    cfg_wr(1'b0, 32'h106);
    cfg_wr(1'b1, 32'h0000_1234);
    cfg_rd(1'b1, d);
    chk("R3 unmapped read", d, 32'h0);
    cfg_wr(1'b0, 32'h101);
    cfg_rd(1'b1, d);
    chk("R3 neighbour intact", d, 32'h0000_0407);

    // R11 FIFO1 holds data across FIFO0 activity
    for (int i = 0; i < 3; i++) do_push(1, 32'hC000 + i, g);
    chk("R12 fifo1 count", cnt(1), 32'd3);

    // R4 fill FIFO0 (capacity 64)
    for (int i = 0; i < 64; i++) begin
      do_push(0, 32'hA000 + i, g);
      if (!g) chk("R4 push granted", 32'(g), 32'd1);
    end
    chk("R4 count at cap", cnt(0), 32'd64);
    chk("R4 full", 32'(full_o[0]), 32'd1);
    do_push(0, 32'hFFFF, g);
    chk("R4 push while full", 32'(g), 32'd0);
    chk("R4 count unchanged", cnt(0), 32'd64);

    // R6/R7 pop 10, push 10 more across the wrap, drain in order
    for (int i = 0; i < 10; i++) begin
      do_pop(0, g, d);
      chk("R6 order", d, 32'hA000 + i);
    end
    for (int j = 0; j < 10; j++) do_push(0, 32'hB000 + j, g);
    chk("R7 count after wrap", cnt(0), 32'd64);
    for (int i = 10; i < 64; i++) begin
      do_pop(0, g, d);
      chk("R6 order", d, 32'hA000 + i);
    end
    for (int j = 0; j < 10; j++) begin
      do_pop(0, g, d);
      chk("R7 wrapped data", d, 32'hB000 + j);
    end
    chk("R5 empty", 32'(empty_o[0]), 32'd1);

    // R5 pop while empty
    do_pop(0, g, d);
    chk("R5 pop while empty", 32'(g), 32'd0);
    chk("R5 count zero", cnt(0), 32'd0);

    for (int i = 0; i < 3; i++) begin
      do_pop(1, g, d);
      chk("R11 fifo1 data", d, 32'hC000 + i);
    end

    // R9/R10 FIFO3 beats FIFO4; FIFO4 held then granted
    @(negedge clk_i);
    push_valid_i[3] = 1'b1; push_data_i[3*DW +: DW] = 32'h3333;
    push_valid_i[4] = 1'b1; push_data_i[4*DW +: DW] = 32'h4444;
    #1 chk("R9 low index wins", {30'd0, push_ready_o[4], push_ready_o[3]}, 32'b01);
    @(negedge clk_i);
    push_valid_i[3] = 1'b0;
    #1 chk("R10 held push granted", 32'(push_ready_o[4]), 32'd1);
    @(negedge clk_i);
    push_valid_i[4] = 1'b0;
    chk("R12 fifo3 count", cnt(3), 32'd1);
    chk("R10 fifo4 count", cnt(4), 32'd1);
    do_pop(4, g, d);
    chk("R10 fifo4 data", d, 32'h4444);

    // R9 push beats pop of the same FIFO
    do_push(1, 32'h1111, g);
    @(negedge clk_i);
    push_valid_i[1] = 1'b1; push_data_i[1*DW +: DW] = 32'h2222;
    pop_valid_i[1] = 1'b1;
    #1 chk("R9 push over pop", {30'd0, pop_ready_o[1], push_ready_o[1]}, 32'b01);
    @(negedge clk_i);
    push_valid_i[1] = 1'b0;
    #1 chk("R10 held pop granted", 32'(pop_ready_o[1]), 32'd1);
    @(negedge clk_i);
    pop_valid_i[1] = 1'b0;
    chk("R10 held pop data", pop_data_o, 32'h1111);

    // R9 data-register write blocks all grants
    cfg_wr(1'b0, 32'h1FF);
    @(negedge clk_i);
    push_valid_i[2] = 1'b1; push_data_i[2*DW +: DW] = 32'h5555;
    cfg_we_i = 1'b1; cfg_sel_i = 1'b1; cfg_wdata_i = 32'h0;
    #1 chk("R9 cfg blocks", 32'(push_ready_o[2]), 32'd0);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    #1 chk("R10 after cfg", 32'(push_ready_o[2]), 32'd1);
    @(negedge clk_i);
    push_valid_i[2] = 1'b0;

    // R8 reprogramming flushes
    do_push(2, 32'h6666, g);
    chk("R12 fifo2 count", cnt(2), 32'd2);
    cfg_wr(1'b0, 32'h102);
    cfg_wr(1'b1, 32'h0000_080B);
    chk("R8 count flushed", cnt(2), 32'd0);
    chk("R8 empty", 32'(empty_o[2]), 32'd1);
    do_pop(2, g, d);
    chk("R8 no stale pop", 32'(g), 32'd0);
    chk("R8 fifo3 untouched", cnt(3), 32'd1);

    summary();
  end
endmodule